// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The block keeps one 64-bit cycle counter and a bank of 32-bit event counters, all governed by a single control word that software reaches over a simple register read/write port. The cycle counter advances on a clock-enable input. It can be slowed by a divide-by-64 prescaler and held when a debug-permission input withholds consent. Each event counter advances on its own event pulse. Overflows are latched in a status word that software clears by writing ones.

Software issues two self-clearing commands through the control word: one zeroes the cycle counter and one zeroes the event counters. Neither command clears an overflow flag. A privilege input and a partition count split the event counters into two groups. Counters below the partition count belong to the lower level. The global enable gates them, and the zeroing command always reaches them. Counters at or above the partition count belong to the higher level. They ignore the global enable, and only a higher-privilege command zeroes them.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, the control word reads its fixed header with every configurable bit at 0, the overflow status reads 0, and all counters read 0.
- R2: The register port has these addresses: 0 is the control word, 1 is the overflow status, 2 and 3 are the low and high halves of the cycle counter, and 4+i is event counter i. The control word reads bits [31:24] as the implementer code (default 0xC3), bits [23:16] as the identification code (default 0x27), bits [15:11] as the event counter count (6), and bits [10:7] as zero. Bit 6 (long overflow), bit 5 (permission gate), bit 4 (export enable), bit 3 (divide) and bit 0 (enable) read back as written. Bits 2 and 1 always read 0.
- R3: Each counter address can be written and reads back the written value.
- R4: While enable is 0, neither the cycle counter nor any event counter below the partition count advances.
- R5: While enable is 1 and divide is 0, the cycle counter gains 1 for each clock in which the clock-enable input is high, and event counter i gains 1 for each clock in which its event pulse is high.
- R6: While the permission gate bit is 1 and the permit input is low, the cycle counter holds. While the gate bit is 0, the permit input has no effect.
- R7: While divide is 1, the cycle counter gains 1 once every 64 enabled clocks. The prescaler advances only on enabled clocks, so the first count after a cycle-counter zeroing comes on the 64th enabled clock.
- R8: With long overflow at 0, status bit 31 sets when an increment takes cycle bit 31 from 1 to 0. With long overflow at 1, it sets only when an increment takes cycle bit 63 from 1 to 0.
- R9: Status bit i sets when event counter i wraps from all ones to zero.
- R10: Writing a 1 to a bit at address 1 clears that status bit, and writing a 0 leaves it unchanged. Only bits 31 and [5:0] can ever read as 1.
- R11: Writing 1 to control bit 2 zeroes the cycle counter and the prescaler and leaves status bit 31 as it was.
- R12: Writing 1 to control bit 1 zeroes every event counter when the privilege input is high. When the privilege input is low, it zeroes only the counters below the partition count. It clears no status bit.
- R13: Event counters at or above the partition count advance on their pulses even while enable is 0.
- R14: When a zeroing command and an increment fall in the same clock, the counter reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cyc_tick | input | 1 | Clock-enable for the cycle counter |
| evt_pulse | input | NUM_EVT | One event pulse per event counter |
| count_permit | input | 1 | Debug permission to count |
| hi_priv | input | 1 | High when the command comes from the higher privilege level |
| part_n | input | 5 | Partition count; event counters from this index up are reserved |

## Verification
Every result appears one clock after its cause. A write, an increment, an overflow flag or a zeroing command shows up on the port read immediately after the rising edge that captured it. The bench drives inputs on falling edges and holds each stimulus for a whole number of cycles. It reads results on the next falling edge, half a cycle after they are due. The divide-by-64 case is checked after exactly 63 enabled clocks and again after the 64th, which pins the cycle on which the count lands.

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NUM_EVT = 6,
  parameter int DIV_W = 6,
  parameter logic [7:0] IMPL_CODE = 8'hC3,
  parameter logic [7:0] ID_CODE = 8'h27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               cyc_tick,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               count_permit,
  input  logic               hi_priv,
  input  logic [4:0]         part_n
);
  localparam logic [31:0] OVF_MASK = 32'h8000_0000 | 32'((64'd1 << NUM_EVT) - 64'd1);

  logic long_ovf, perm_gate, export_en, div64, enable;
  logic [63:0] cyc_q;
  logic [NUM_EVT-1:0][31:0] evt_q;
  logic [31:0] ovf_q;
  logic [DIV_W-1:0] pre_q;

  wire ctl_wr  = reg_wr && reg_addr == 4'd0;
  wire ovf_wr  = reg_wr && reg_addr == 4'd1;
  wire cyc_wlo = reg_wr && reg_addr == 4'd2;
  wire cyc_whi = reg_wr && reg_addr == 4'd3;
  wire cyc_clr = ctl_wr && reg_wdata[2];
  wire evt_cmd = ctl_wr && reg_wdata[1];

  wire cyc_run = enable && cyc_tick && !(perm_gate && !count_permit);
  wire cyc_inc = cyc_run && (!div64 || &pre_q);
  wire [63:0] cyc_nxt = cyc_q + 64'd1;
  wire cyc_ovf = cyc_inc && !cyc_clr && !cyc_wlo && !cyc_whi &&
                 (long_ovf ? (cyc_q[63] && !cyc_nxt[63]) : (cyc_q[31] && !cyc_nxt[31]));

  logic [NUM_EVT-1:0] rsv, evt_clr, evt_wr, evt_inc, evt_ovf;
  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      rsv[i]     = i >= int'(part_n);
      evt_clr[i] = evt_cmd && (hi_priv || !rsv[i]);
      evt_wr[i]  = reg_wr && reg_addr == 4'(4 + i);
      evt_inc[i] = evt_pulse[i] && (enable || rsv[i]);
      evt_ovf[i] = evt_inc[i] && !evt_clr[i] && !evt_wr[i] && &evt_q[i];
    end
  end

  wire [31:0] ovf_set = {cyc_ovf, 31'b0} | 32'(evt_ovf);
  wire [31:0] ovf_wipe = ovf_wr ? (reg_wdata & OVF_MASK) : 32'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {long_ovf, perm_gate, export_en, div64, enable} <= '0;
      cyc_q <= '0;
      evt_q <= '0;
      ovf_q <= '0;
      pre_q <= '0;
    end else begin
      if (ctl_wr)
        {long_ovf, perm_gate, export_en, div64} <= reg_wdata[6:3];
      if (ctl_wr)
        enable <= reg_wdata[0];

      if (cyc_clr)
        pre_q <= '0;
      else if (cyc_run && div64)
        pre_q <= pre_q + 1'b1;

      if (cyc_clr)
        cyc_q <= '0;
      else if (cyc_wlo)
        cyc_q[31:0] <= reg_wdata;
      else if (cyc_whi)
        cyc_q[63:32] <= reg_wdata;
      else if (cyc_inc)
        cyc_q <= cyc_nxt;

      for (int i = 0; i < NUM_EVT; i++) begin
        if (evt_clr[i])
          evt_q[i] <= '0;
        else if (evt_wr[i])
          evt_q[i] <= reg_wdata;
        else if (evt_inc[i])
          evt_q[i] <= evt_q[i] + 32'd1;
      end

      ovf_q <= (ovf_q & ~ovf_wipe) | ovf_set;
    end
  end

  wire [31:0] ctrl_rd = {IMPL_CODE, ID_CODE, 5'(NUM_EVT), 4'b0,
                         long_ovf, perm_gate, export_en, div64, 2'b00, enable};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata = ctrl_rd;
      4'd1: reg_rdata = ovf_q;
      4'd2: reg_rdata = cyc_q[31:0];
      4'd3: reg_rdata = cyc_q[63:32];
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (reg_addr == 4'(4 + i)) reg_rdata = evt_q[i];
      end
    endcase
  end
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk #(
  parameter int NUM_EVT = 6,
  parameter logic [7:0] IMPL_CODE = 8'hC3,
  parameter logic [7:0] ID_CODE = 8'h27
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [3:0]              reg_addr,
  input logic                    cmd_c,
  input logic                    cmd_p,
  input logic [31:0]             reg_rdata,
  input logic                    hi_priv,
  input logic                    enable,
  input logic [63:0]             cyc_q,
  input logic [NUM_EVT*32-1:0]   evt_flat,
  input logic [31:0]             ovf_q
);
  localparam logic [31:0] OVF_MASK = 32'h8000_0000 | 32'((64'd1 << NUM_EVT) - 64'd1);
  localparam logic [31:0] HDR = {IMPL_CODE, ID_CODE, 5'(NUM_EVT), 11'b0};

  wire ctl_wr = reg_wr && reg_addr == 4'd0;

  a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 4'd0 |-> (reg_rdata & 32'hFFFF_FF86) == HDR);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !reg_wr) |=> $stable(cyc_q));

  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q[31]) |-> cyc_q[31:0] == 32'd0);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    a_r9_evt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[i]) |-> evt_flat[i*32 +: 32] == 32'd0);
  end

  a_r10_status_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q & ~OVF_MASK) == 32'd0);

  a_r11_keep_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmd_c && ovf_q[31]) |=> (ovf_q[31] && cyc_q == 64'd0));

  a_r12_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmd_p && hi_priv) |=> evt_flat == '0);
endmodule

bind perf_mon_unit perf_mon_unit_chk #(
  .NUM_EVT(NUM_EVT), .IMPL_CODE(IMPL_CODE), .ID_CODE(ID_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_c(reg_wdata[2]), .cmd_p(reg_wdata[1]), .reg_rdata(reg_rdata),
  .hi_priv(hi_priv), .enable(enable), .cyc_q(cyc_q), .evt_flat(evt_q), .ovf_q(ovf_q)
);

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 6;
  localparam logic [31:0] HDR = 32'hC327_3000;

  logic clk = 0, rst_n = 0, reg_wr = 0, cyc_tick = 0, count_permit = 1, hi_priv = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [NE-1:0] evt_pulse = 0;
  logic [4:0] part_n = 5'd6;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_mon_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_tick(cyc_tick),
    .evt_pulse(evt_pulse), .count_permit(count_permit), .hi_priv(hi_priv),
    .part_n(part_n)
  );

  localparam logic [63:0] VEC [5] = '{
    {32'hFFFF_FFFF, HDR | 32'h79},
    {32'h0000_0000, HDR},
    {32'h0000_0006, HDR},
    {32'h0000_0048, HDR | 32'h48},
    {32'h0000_0021, HDR | 32'h21}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd_cyc(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'd2, lo);
    rd(4'd3, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    cyc_tick = 1;
    repeat (n) @(negedge clk);
    cyc_tick = 0;
  endtask

  task automatic pulse(input logic [NE-1:0] m, input int n);
    evt_pulse = m;
    repeat (n) @(negedge clk);
    evt_pulse = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(4'd0, v); chk("R1 control after reset", 64'(v), 64'(HDR));
    rd(4'd1, v); chk("R1 status after reset", 64'(v), 0);
    rd_cyc(c);   chk("R1 cycle after reset", c, 0);

    for (int k = 0; k < 5; k++) begin
      wr(4'd0, VEC[k][63:32]);
      rd(4'd0, v);
      chk("R2 control readback", 64'(v), 64'(VEC[k][31:0]));
    end
    wr(4'd0, 32'h0);

    ticks(5); pulse(6'b000100, 3);
    rd_cyc(c);   chk("R4 cycle held while disabled", c, 0);
    rd(4'd6, v); chk("R4 event held while disabled", 64'(v), 0);

    wr(4'd0, 32'h1);
    ticks(10);
    rd_cyc(c);   chk("R5 cycle counts ticks", c, 10);
    pulse(6'b000100, 3);
    rd(4'd6, v); chk("R5 event counts pulses", 64'(v), 3);

    wr(4'd0, 32'h21);
    count_permit = 0; ticks(5);
    rd_cyc(c);   chk("R6 gate stops cycle", c, 10);
    count_permit = 1; ticks(3);
    rd_cyc(c);   chk("R6 gate with permit", c, 13);
    wr(4'd0, 32'h1);
    count_permit = 0; ticks(2); count_permit = 1;
    rd_cyc(c);   chk("R6 permit ignored when gate off", c, 15);

    wr(4'd0, 32'h0D);
    rd_cyc(c);   chk("R11 zero command clears cycle", c, 0);
    ticks(63);
    rd_cyc(c);   chk("R7 no count before 64th", c, 0);
    ticks(1);
    rd_cyc(c);   chk("R7 count on 64th", c, 1);

    wr(4'd2, 32'hFFFF_FFFE); wr(4'd3, 32'h0);
    rd_cyc(c);   chk("R3 cycle write readback", c, 64'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    ticks(2);
    rd_cyc(c);   chk("R8 cycle crosses bit 31", c, 64'h1_0000_0000);
    rd(4'd1, v); chk("R8 short overflow flag", 64'(v), 64'h8000_0000);
    wr(4'd1, 32'h7FFF_FFFF);
    rd(4'd1, v); chk("R10 zero bits keep flag", 64'(v), 64'h8000_0000);
    wr(4'd1, 32'h8000_0000);
    rd(4'd1, v); chk("R10 one clears flag", 64'(v), 0);

    wr(4'd0, 32'h41);
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'h0);
    ticks(1);
    rd(4'd1, v); chk("R8 long mode ignores bit 31", 64'(v), 0);
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
    ticks(1);
    rd_cyc(c);   chk("R8 long wrap to zero", c, 0);
    rd(4'd1, v); chk("R8 long overflow flag", 64'(v), 64'h8000_0000);

    wr(4'd2, 32'h123);
    wr(4'd0, 32'h05);
    rd_cyc(c);   chk("R11 cycle zeroed", c, 0);
    rd(4'd1, v); chk("R11 flag kept", 64'(v), 64'h8000_0000);

    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R3 event write readback", 64'(v), 64'hFFFF_FFFF);
    pulse(6'b000010, 1);
    rd(4'd5, v); chk("R9 event wraps", 64'(v), 0);
    rd(4'd1, v); chk("R9 event flag", 64'(v), 64'h8000_0002);

    part_n = 5'd3; hi_priv = 0;
    wr(4'd4, 32'd5); wr(4'd8, 32'd7);
    wr(4'd0, 32'h03);
    rd(4'd4, v); chk("R12 low counter zeroed", 64'(v), 0);
    rd(4'd8, v); chk("R12 reserved counter kept", 64'(v), 7);
    rd(4'd1, v); chk("R12 flags kept", 64'(v), 64'h8000_0002);
    hi_priv = 1;
    wr(4'd0, 32'h03);
    rd(4'd8, v); chk("R12 high level zeroes reserved", 64'(v), 0);

    wr(4'd0, 32'h0);
    pulse(6'b010001, 2);
    rd(4'd8, v); chk("R13 reserved counts with enable off", 64'(v), 2);
    rd(4'd4, v); chk("R13 low counter still held", 64'(v), 0);

    wr(4'd0, 32'h1);
    ticks(3); pulse(6'b000100, 2);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h07;
    evt_pulse = 6'b000100; cyc_tick = 1;
    @(negedge clk);
    reg_wr = 0; evt_pulse = 0; cyc_tick = 0;
    rd(4'd6, v); chk("R14 event zero beats increment", 64'(v), 0);
    rd_cyc(c);   chk("R14 cycle zero beats increment", c, 0);

    done = 1;
    finish_run();
  end
endmodule